// File: doc/BRIEF.md
# Serial Character Receiver with Error Detection

This block turns an asynchronous serial line into parallel characters. Bit timing comes from a one-cycle enable pulse that occurs sixteen times per bit period (the factor is a parameter), so the block runs entirely in the system clock domain. After a falling edge, the receiver waits half a bit period and checks that the line is still low. It then samples each later bit in the middle of its period and builds the character least significant bit first.

A completed character goes into an output holding register and raises a ready flag. The character stays on the output while the next one is being shifted in, and a read strobe lowers the ready flag. Three error conditions are reported on separate sticky outputs: a character that completes before the previous one was read, a stop bit found low while the data was not all zero (a framing fault), and a stop bit found low with every data bit low (a break on the line). The surrounding logic is expected to reset the receiver when any of these flags rises.

Top module: `serial_rx`

## Requirements
- R1: While reset is high and after it is released, the data output is 0, the ready flag is 0 and all three error flags are 0.
- R2: With the default format (one start bit low, eight data bits sent least significant bit first, one stop bit high), the character appears on the data output and the ready flag reads 1 before the end of the stop bit.
- R3: A low pulse on the line that has returned high by the mid-start sample, taken 8 enables after the low level is first seen, is ignored: ready and all error flags stay 0.
- R4: A one-cycle read strobe while ready is 1 clears ready in the following cycle, and the data output keeps its value.
- R5: While ready is 1 and a new character is being shifted in, the data output keeps the previous character.
- R6: If a character completes while ready is still 1 and no read arrives in that cycle, the overrun flag becomes 1, ready stays 1 and the data output keeps the older character. The new character is dropped.
- R7: If a stop bit is sampled low and the data bits were not all zero, the framing flag (err_framing) becomes 1, the break flag stays 0, ready is not raised and the data output is unchanged.
- R8: If a stop bit is sampled low and all data bits were zero, the break flag (err_break) becomes 1, the framing flag stays 0 and ready is not raised.
- R9: Once an error flag is 1, it stays 1 through any later line activity until reset, and reset clears it.
- R10: Only cycles with the enable input high advance the bit timing. With the enable held low, a whole frame on the line leaves ready and all error flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at CLK_FACTOR times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rd | input | 1 | Read strobe, clears the ready flag |
| data_out | output | DATA_BITS | Last accepted character |
| data_ready | output | 1 | A character is waiting to be read |
| err_overrun | output | 1 | Sticky: a character completed while the previous one was unread |
| err_framing | output | 1 | Sticky: stop bit low with non-zero data |
| err_break | output | 1 | Sticky: stop bit low with all-zero data |

## Verification
The hardest case to reach from the ports is the overrun collision, where a second character completes while the first is still unread. The hold guarantee for the older character can only be seen in the middle of that second frame. The bench sends one character without reading it. Partway through the next frame it checks that the output still carries the first character. After the second frame ends, it checks the overrun flag and that the older data was kept. Short start glitches, stop bits forced low with zero and non-zero data, and a frame sent with the enable gated off are driven as directed cases. Bytes drawn from a fixed seed exercise the normal path.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_START = 2'd1,
        SR_DATA  = 2'd2,
        SR_STOP  = 2'd3
    } sr_state_e;
endpackage

// File: rtl/sr_line_sync.sv
module sr_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = line_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{s1: 1'b1, s2: 1'b1};
        else     q <= d;
    end

    assign line_o = q.s2;
endmodule

// File: rtl/sr_frame_fsm.sv
module sr_frame_fsm #(
    parameter int START_BITS = 1,
    parameter int DATA_BITS  = 8,
    parameter int STOP_BITS  = 1,
    parameter int CLK_FACTOR = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rx,
    output logic                 done,
    output logic                 set_framing,
    output logic                 set_break,
    output logic [DATA_BITS-1:0] char_o
);
    import serial_rx_pkg::*;

    localparam int HALF  = CLK_FACTOR / 2;
    localparam int CW    = $clog2(CLK_FACTOR + 1);
    localparam int MAXA  = (START_BITS > STOP_BITS) ? START_BITS : STOP_BITS;
    localparam int MAXB  = (MAXA > DATA_BITS) ? MAXA : DATA_BITS;
    localparam int IW    = $clog2(MAXB + 1);
    localparam logic [CW-1:0] LIM_HALF = CW'(HALF);
    localparam logic [CW-1:0] LIM_FULL = CW'(CLK_FACTOR);

    typedef struct packed {
        sr_state_e            st;
        logic [CW-1:0]        cnt;
        logic                 first;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] shreg;
        logic                 done;
        logic                 fr;
        logic                 brk;
    } fsm_t;

    fsm_t d, q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] lim;
    logic [IW-1:0] idx_inc;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.fr    = 1'b0;
        d.brk   = 1'b0;
        cnt_inc = q.cnt + 1'b1;
        lim     = q.first ? LIM_HALF : LIM_FULL;
        idx_inc = q.idx + 1'b1;
        if (tick) begin
            if (q.st == SR_IDLE) begin
                if (!rx) begin
                    d.st    = SR_START;
                    d.cnt   = '0;
                    d.first = 1'b1;
                    d.idx   = '0;
                end
            end else if (cnt_inc == lim) begin
                d.cnt   = '0;
                d.first = 1'b0;
                d.idx   = idx_inc;
                case (q.st)
                    SR_START: begin
                        if (rx) begin
                            d.st = SR_IDLE;
                        end else if (idx_inc == IW'(START_BITS)) begin
                            d.st  = SR_DATA;
                            d.idx = '0;
                        end
                    end
                    SR_DATA: begin
                        d.shreg = {rx, q.shreg[DATA_BITS-1:1]};
                        if (idx_inc == IW'(DATA_BITS)) begin
                            d.st  = SR_STOP;
                            d.idx = '0;
                        end
                    end
                    default: begin
                        if (!rx) begin
                            d.st = SR_IDLE;
                            if (q.shreg == '0) d.brk = 1'b1;
                            else               d.fr  = 1'b1;
                        end else if (idx_inc == IW'(STOP_BITS)) begin
                            d.st   = SR_IDLE;
                            d.done = 1'b1;
                        end
                    end
                endcase
            end else begin
                d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: SR_IDLE, cnt: '0, first: 1'b0, idx: '0,
                        shreg: '0, done: 1'b0, fr: 1'b0, brk: 1'b0};
        else     q <= d;
    end

    assign done        = q.done;
    assign set_framing = q.fr;
    assign set_break   = q.brk;
    assign char_o      = q.shreg;

    AST_DONE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        q.done |-> $past(tick)); // R10
    AST_NO_DONE_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(q.done && (q.fr || q.brk))); // R7
endmodule

// File: rtl/sr_char_hold.sv
module sr_char_hold #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] char_i,
    input  logic                 set_framing,
    input  logic                 set_break,
    input  logic                 rd,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 ready_o,
    output logic                 ovr_o,
    output logic                 fr_o,
    output logic                 brk_o
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ready;
        logic                 ovr;
        logic                 fr;
        logic                 brk;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (set_framing) d.fr  = 1'b1;
        if (set_break)   d.brk = 1'b1;
        if (done) begin
            if (q.ready && !rd) begin
                d.ovr = 1'b1;
            end else begin
                d.data  = char_i;
                d.ready = 1'b1;
            end
        end else if (rd) begin
            d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{data: '0, ready: 1'b0, ovr: 1'b0, fr: 1'b0, brk: 1'b0};
        else     q <= d;
    end

    assign data_o  = q.data;
    assign ready_o = q.ready;
    assign ovr_o   = q.ovr;
    assign fr_o    = q.fr;
    assign brk_o   = q.brk;

    AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        q.ready && rd && !done |=> !q.ready); // R4
    AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(q.data)); // R5
    AST_COLLISION_FLAGS: assert property (@(posedge clk) disable iff (rst)
        done && q.ready && !rd |=> q.ovr && q.ready && $stable(q.data)); // R6
    AST_FRAMING_STICKY: assert property (@(posedge clk) disable iff (rst)
        q.fr |=> q.fr); // R9
    AST_BREAK_STICKY: assert property (@(posedge clk) disable iff (rst)
        q.brk |=> q.brk); // R9
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
    parameter int START_BITS = 1,
    parameter int DATA_BITS  = 8,
    parameter int STOP_BITS  = 1,
    parameter int CLK_FACTOR = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 rxd,
    input  logic                 rd,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 data_ready,
    output logic                 err_overrun,
    output logic                 err_framing,
    output logic                 err_break
);
    logic                 rx_s;
    logic                 done;
    logic                 set_fr;
    logic                 set_brk;
    logic [DATA_BITS-1:0] char_w;

    sr_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (rxd),
        .line_o (rx_s)
    );

    sr_frame_fsm #(
        .START_BITS (START_BITS),
        .DATA_BITS  (DATA_BITS),
        .STOP_BITS  (STOP_BITS),
        .CLK_FACTOR (CLK_FACTOR)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_en),
        .rx          (rx_s),
        .done        (done),
        .set_framing (set_fr),
        .set_break   (set_brk),
        .char_o      (char_w)
    );

    sr_char_hold #(
        .DATA_BITS (DATA_BITS)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .char_i      (char_w),
        .set_framing (set_fr),
        .set_break   (set_brk),
        .rd          (rd),
        .data_o      (data_out),
        .ready_o     (data_ready),
        .ovr_o       (err_overrun),
        .fr_o        (err_framing),
        .brk_o       (err_break)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !data_ready && !err_overrun && !err_framing && !err_break); // R1
endmodule

// File: tb/tb_serial_rx.sv
`timescale 1ns/1ps
module tb_serial_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       rxd = 1'b1;
    logic       rd = 1'b0;
    logic [7:0] data_out;
    logic       data_ready, err_overrun, err_framing, err_break;
    logic       gate = 1'b1;
    logic [1:0] div = '0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div     <= div + 1'b1;
        tick_en <= gate && (div == 2'd3);
    end

    serial_rx dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rxd(rxd), .rd(rd),
        .data_out(data_out), .data_ready(data_ready),
        .err_overrun(err_overrun), .err_framing(err_framing), .err_break(err_break)
    );

    // expected fault flags {break, framing} for a frame
    function automatic logic [1:0] exp_fault(logic [7:0] d, logic stop_v);
        if (stop_v) return 2'b00;
        return (d == 8'h00) ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        repeat (64) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stop_v);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(stop_v);
        rxd = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        #(2_000_000ns);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b, r;
        logic [1:0] ef;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R1 reset state while held
        chk(data_out == 8'h00 && !data_ready, "R1", "data/ready in reset",
            {data_out, data_ready}, 0);
        do_reset();
        chk({err_overrun, err_framing, err_break} == 3'b000, "R1", "flags after reset",
            {err_overrun, err_framing, err_break}, 0);
        chk(!data_ready, "R1", "ready after reset", data_ready, 0);

        // R2 directed corners then random bytes
        for (int n = 0; n < 14; n++) begin
            if (n == 0)      r = 8'h01;
            else if (n == 1) r = 8'h80;
            else if (n == 2) r = 8'hFF;
            else             r = 8'($urandom());
            send_frame(r, 1'b1);
            chk(data_ready, "R2", "ready after frame", data_ready, 1);
            chk(data_out == r, "R2", "received char", data_out, r);
            pulse_read();
            chk(!data_ready, "R4", "ready cleared by read", data_ready, 0);
            chk(data_out == r, "R4", "data kept after read", data_out, r);
            repeat (20) @(negedge clk);
        end

        // R3 short start glitch (3 enables low)
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        chk(!data_ready && {err_overrun, err_framing, err_break} == 3'b000,
            "R3", "glitch ignored", {data_ready, err_overrun, err_framing, err_break}, 0);
        r = 8'h5A;
        send_frame(r, 1'b1);
        chk(data_ready && data_out == r, "R3", "frame after glitch", data_out, r);
        pulse_read();

        // R5 / R6 collision
        a = 8'($urandom());
        b = ~a;
        send_frame(a, 1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 5; i++) send_bit(b[i]);
        chk(data_out == a && data_ready, "R5", "old char held mid-frame", data_out, a);
        for (int i = 5; i < 8; i++) send_bit(b[i]);
        send_bit(1'b1);
        chk(err_overrun, "R6", "overrun flag", err_overrun, 1);
        chk(data_ready && data_out == a, "R6", "older char kept", data_out, a);
        do_reset();

        // R7 framing fault
        r = 8'h3C;
        send_frame(8'h11, 1'b1);
        pulse_read();
        ef = exp_fault(r, 1'b0);
        send_frame(r, 1'b0);
        chk({err_break, err_framing} == ef, "R7", "framing flags",
            {err_break, err_framing}, ef);
        chk(!data_ready && data_out == 8'h11, "R7", "no ready, data unchanged",
            {data_ready, data_out}, 8'h11);
        // R9 sticky through later activity
        repeat (800) @(negedge clk);
        send_frame(8'hA5, 1'b1);
        chk(err_framing, "R9", "framing stays set", err_framing, 1);
        do_reset();
        chk(!err_framing, "R9", "reset clears framing", err_framing, 0);

        // R8 break
        ef = exp_fault(8'h00, 1'b0);
        send_frame(8'h00, 1'b0);
        chk({err_break, err_framing} == ef, "R8", "break flags",
            {err_break, err_framing}, ef);
        chk(!data_ready, "R8", "no ready on break", data_ready, 0);
        repeat (800) @(negedge clk);
        chk(err_break, "R9", "break stays set", err_break, 1);
        do_reset();
        chk(!err_break, "R9", "reset clears break", err_break, 0);

        // R10 enable gated off
        gate = 1'b0;
        send_frame(8'h96, 1'b1);
        repeat (100) @(negedge clk);
        chk(!data_ready && {err_overrun, err_framing, err_break} == 3'b000,
            "R10", "no activity without enable",
            {data_ready, err_overrun, err_framing, err_break}, 0);
        gate = 1'b1;
        repeat (100) @(negedge clk);
        send_frame(8'h69, 1'b1);
        chk(data_ready && data_out == 8'h69, "R10", "resumes with enable", data_out, 8'h69);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule